// File: doc/BRIEF.md
# Stereo Serial Audio Receiver with Per-Channel Auto-Mute

This block takes two-channel 24-bit PCM audio from a three-wire serial port (bit clock, word clock, serial data) and turns it into parallel samples. A faster system clock oversamples the port. A static format pin selects between standard I2S framing and left-justified framing. After the second (right) channel of each frame has been captured, the left and right words appear together on the parallel outputs with a one-cycle valid strobe.

Each channel has its own zero-run detector. When detection is enabled and a channel delivers a programmable number of consecutive all-zero words, its mute flag goes high. The default number is 2048. The run is counted in words, not in time, so the threshold is the same at every sample rate from 32 kHz to 48 kHz. The first non-zero word on a muted channel releases its mute. A downstream volume stage can use the two flags to silence each channel.

Top module: `stereo_serial_rx`

## Requirements
- R1: While reset is asserted and right after it: leftSample and rightSample read zero, sampleValid is low, and leftMuted and rightMuted are low.
- R2: With fmtLeftJust = 0 (I2S), a word belongs to the left channel when the word clock is low and to the right channel when it is high. Its MSB is taken on the second rising bit-clock edge after a word-clock transition. The following 23 rising edges supply the remaining bits, MSB first.
- R3: With fmtLeftJust = 1 (left-justified), a word belongs to the left channel when the word clock is high and to the right channel when it is low. Its MSB is taken on the first rising bit-clock edge after a word-clock transition, and the remaining 23 bits follow MSB first.
- R4: In a channel slot, any bit-clock periods after the 24th data bit carry no data. Their values have no effect on the samples.
- R5: When the right word of a frame completes, sampleValid pulses high for exactly one system clock. In that same cycle, leftSample and rightSample show the frame's left and right words. At all other times the two outputs hold their values.
- R6: With zeroMuteEn = 1, each channel counts its own consecutive all-zero words. Its mute flag rises when the count reaches ZERO_RUN (default 2048). The count on one channel has no effect on the other channel's flag.
- R7: A non-zero word on a channel, even one with only the LSB set, clears that channel's mute flag and restarts its zero count from zero.
- R8: While zeroMuteEn = 0, both mute flags and both counts are cleared within one system clock. After re-enabling, a full ZERO_RUN zero words are needed again before a flag rises.
- R9: When the right word that completes the zero run is captured, rightMuted is already high in the same cycle that sampleValid pulses for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial port |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial bit clock (asynchronous) |
| wordClk | input | 1 | Left/right word clock (asynchronous) |
| serData | input | 1 | Serial audio data, MSB first |
| fmtLeftJust | input | 1 | Framing select: 0 = I2S, 1 = left-justified (static) |
| zeroMuteEn | input | 1 | Enables per-channel zero-run mute |
| leftSample | output | SAMPLE_W | Left word of the last complete frame |
| rightSample | output | SAMPLE_W | Right word of the last complete frame |
| sampleValid | output | 1 | One-cycle pulse when a new stereo pair is presented |
| leftMuted | output | 1 | Left channel is muted by the zero-run detector |
| rightMuted | output | 1 | Right channel is muted by the zero-run detector |

## Verification
Sample publication and mute assertion can happen on the same system-clock edge. This occurs when the right word that completes a zero run is also the word that ends the frame. The bench drives the right channel with exactly ZERO_RUN zero words. At the sampleValid pulse it records the outputs and requires that rightMuted is already high and rightSample is zero, while the left flag keeps its own independent state. A second case has disable and an almost-complete run meet. The bench takes the count to one word short of the threshold, pulses zeroMuteEn low, and then checks that one more zero word does not mute the channel.

// File: rtl/stereo_serial_rx_pkg.sv
package stereo_serial_rx_pkg;

  // Per-bit strobe passed from the framing control to the datapath.
  typedef struct packed {
    logic shiftEn;   // one serial bit is ready
    logic bitVal;    // value of that bit
    logic lastBit;   // bit completes a word
    logic isLeft;    // word belongs to the left channel
  } rx_strobe_t;

endpackage

// File: rtl/stereo_serial_rx_ctrl.sv
module stereo_serial_rx_ctrl
  import stereo_serial_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClk,
  input  logic       wordClk,
  input  logic       serData,
  input  logic       fmtLeftJust,
  output rx_strobe_t stb
);

  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SAMPLE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SAMPLE_W);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

  // Two-flop synchronisers, all with the same latency.
  logic [1:0] bclkSync;
  logic [1:0] wclkSync;
  logic [1:0] dataSync;
  logic       bclkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkSync <= '0;
      wclkSync <= '0;
      dataSync <= '0;
      bclkPrev <= 1'b0;
    end else begin
      bclkSync <= {bclkSync[0], bitClk};
      wclkSync <= {wclkSync[0], wordClk};
      dataSync <= {dataSync[0], serData};
      bclkPrev <= bclkSync[1];
    end
  end

  logic bclkRise;
  logic wcNow;
  logic dNow;
  assign bclkRise = bclkSync[1] & ~bclkPrev;
  assign wcNow    = wclkSync[1];
  assign dNow     = dataSync[1];

  // Framing state.
  logic [CNT_W-1:0] bitCnt;     // bits already taken in the current word
  logic             skipOne;    // I2S: one edge to let pass before the MSB
  logic             prevWord;   // word clock at the previous rising edge
  logic             curLeft;    // channel of the word in progress
  logic             newIsLeft;

  // Left is word clock low for I2S and high for left-justified.
  assign newIsLeft = (wcNow == fmtLeftJust);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt   <= FULL_CNT;
      skipOne  <= 1'b0;
      prevWord <= 1'b0;
      curLeft  <= 1'b0;
      stb      <= '0;
    end else begin
      stb <= '0;
      if (bclkRise) begin
        prevWord <= wcNow;
        if (wcNow != prevWord) begin
          curLeft <= newIsLeft;
          if (fmtLeftJust) begin
            stb.shiftEn <= 1'b1;
            stb.bitVal  <= dNow;
            stb.lastBit <= (SAMPLE_W == 1);
            stb.isLeft  <= newIsLeft;
            bitCnt      <= ONE_CNT;
            skipOne     <= 1'b0;
          end else begin
            bitCnt  <= '0;
            skipOne <= 1'b1;
          end
        end else if (skipOne || (bitCnt != '0 && bitCnt < FULL_CNT)) begin
          skipOne     <= 1'b0;
          stb.shiftEn <= 1'b1;
          stb.bitVal  <= dNow;
          stb.lastBit <= (bitCnt == LAST_IDX);
          stb.isLeft  <= curLeft;
          bitCnt      <= bitCnt + ONE_CNT;
        end
      end
    end
  end

endmodule

// File: rtl/stereo_serial_rx_zmute.sv
module stereo_serial_rx_zmute #(
  parameter int ZERO_RUN = 2048
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic wordDone,
  input  logic wordIsZero,
  output logic muted
);

  localparam int RUN_W = $clog2(ZERO_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(ZERO_RUN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(ZERO_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

  logic [RUN_W-1:0] zeroCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      zeroCnt <= '0;
      muted   <= 1'b0;
    end else if (wordDone) begin
      if (wordIsZero) begin
        if (zeroCnt != RUN_MAX) zeroCnt <= zeroCnt + RUN_ONE;
        if (zeroCnt == RUN_LAST) muted <= 1'b1;
      end else begin
        zeroCnt <= '0;
        muted   <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/stereo_serial_rx_dpath.sv
module stereo_serial_rx_dpath
  import stereo_serial_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int ZERO_RUN = 2048,
  parameter int NUM_CH   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                zeroMuteEn,
  input  rx_strobe_t          stb,
  output logic [SAMPLE_W-1:0] leftSample,
  output logic [SAMPLE_W-1:0] rightSample,
  output logic                sampleValid,
  output logic [NUM_CH-1:0]   chanMuted
);

  logic [SAMPLE_W-1:0] shiftReg;
  logic [SAMPLE_W-1:0] leftHold;
  logic [SAMPLE_W-1:0] newWord;
  logic                wordEnd;

  assign newWord = {shiftReg[SAMPLE_W-2:0], stb.bitVal};
  assign wordEnd = stb.shiftEn & stb.lastBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      leftHold    <= '0;
      leftSample  <= '0;
      rightSample <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (stb.shiftEn) shiftReg <= newWord;
      if (wordEnd) begin
        if (stb.isLeft) begin
          leftHold <= newWord;
        end else begin
          leftSample  <= leftHold;
          rightSample <= newWord;
          sampleValid <= 1'b1;
        end
      end
    end
  end

  // One zero-run detector per channel; index 0 is left.
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_zmute
    logic chDone;
    assign chDone = wordEnd & (stb.isLeft == (ch == 0));
    stereo_serial_rx_zmute #(.ZERO_RUN(ZERO_RUN)) i_zmute (
      .clk        (clk),
      .rstN       (rstN),
      .enable     (zeroMuteEn),
      .wordDone   (chDone),
      .wordIsZero (newWord == '0),
      .muted      (chanMuted[ch])
    );
  end

endmodule

// File: rtl/stereo_serial_rx.sv
module stereo_serial_rx
  import stereo_serial_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int ZERO_RUN = 2048
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bitClk,
  input  logic                wordClk,
  input  logic                serData,
  input  logic                fmtLeftJust,
  input  logic                zeroMuteEn,
  output logic [SAMPLE_W-1:0] leftSample,
  output logic [SAMPLE_W-1:0] rightSample,
  output logic                sampleValid,
  output logic                leftMuted,
  output logic                rightMuted
);

  localparam int NUM_CH = 2;

  rx_strobe_t        stb;
  logic [NUM_CH-1:0] chanMuted;

  stereo_serial_rx_ctrl #(.SAMPLE_W(SAMPLE_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .bitClk      (bitClk),
    .wordClk     (wordClk),
    .serData     (serData),
    .fmtLeftJust (fmtLeftJust),
    .stb         (stb)
  );

  stereo_serial_rx_dpath #(
    .SAMPLE_W (SAMPLE_W),
    .ZERO_RUN (ZERO_RUN),
    .NUM_CH   (NUM_CH)
  ) i_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .zeroMuteEn  (zeroMuteEn),
    .stb         (stb),
    .leftSample  (leftSample),
    .rightSample (rightSample),
    .sampleValid (sampleValid),
    .chanMuted   (chanMuted)
  );

  assign leftMuted  = chanMuted[0];
  assign rightMuted = chanMuted[1];

endmodule

// File: rtl/stereo_serial_rx_checker.sv
module stereo_serial_rx_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rstN,
  input logic                zeroMuteEn,
  input logic [SAMPLE_W-1:0] leftSample,
  input logic [SAMPLE_W-1:0] rightSample,
  input logic                sampleValid,
  input logic                leftMuted,
  input logic                rightMuted
);

  // R5: the valid strobe lasts one cycle
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  // R5: outputs change only together with the strobe
  p_hold_outputs_r5: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> ($stable(leftSample) && $stable(rightSample)));

  // R8: disabling clears both flags on the next edge
  p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    !zeroMuteEn |=> (!leftMuted && !rightMuted));

  // R6: a mute flag can only be high when detection was enabled
  p_flag_needs_enable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (leftMuted || rightMuted) |-> $past(zeroMuteEn));

  // R9: right mute rises together with a zero right sample
  p_mute_on_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rightMuted) |-> (sampleValid && rightSample == '0));

  // R7: right unmute while enabled comes with a non-zero sample
  p_unmute_nonzero_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rightMuted) && $past(zeroMuteEn)) |-> (sampleValid && rightSample != '0));

endmodule

bind stereo_serial_rx stereo_serial_rx_checker #(.SAMPLE_W(SAMPLE_W)) i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .zeroMuteEn  (zeroMuteEn),
  .leftSample  (leftSample),
  .rightSample (rightSample),
  .sampleValid (sampleValid),
  .leftMuted   (leftMuted),
  .rightMuted  (rightMuted)
);

// File: tb/test_stereo_serial_rx.sv
module test_stereo_serial_rx;

  localparam int W    = 24;
  localparam int RUN  = 8;
  localparam int SLOT = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0;
  logic wordClk = 1'b0;
  logic serData = 1'b0;
  logic fmtLeftJust = 1'b0;
  logic zeroMuteEn = 1'b1;
  logic [W-1:0] leftSample, rightSample;
  logic sampleValid, leftMuted, rightMuted;

  always #10 clk = ~clk;

  stereo_serial_rx #(.SAMPLE_W(W), .ZERO_RUN(RUN)) i_stereo_serial_rx (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordClk(wordClk),
    .serData(serData), .fmtLeftJust(fmtLeftJust), .zeroMuteEn(zeroMuteEn),
    .leftSample(leftSample), .rightSample(rightSample), .sampleValid(sampleValid),
    .leftMuted(leftMuted), .rightMuted(rightMuted)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Record what the block presents at each strobe.
  int validCnt = 0;
  logic [W-1:0] capL = '0, capR = '0;
  logic capLM = 1'b0, capRM = 1'b0;
  always @(negedge clk) begin
    if (sampleValid) begin
      validCnt++;
      capL  = leftSample;
      capR  = rightSample;
      capLM = leftMuted;
      capRM = rightMuted;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bitTick(input logic wc, input logic d);
    @(negedge clk);
    bitClk = 1'b0; wordClk = wc; serData = d;
    repeat (2) @(negedge clk);
    bitClk = 1'b1;
    @(negedge clk);
  endtask

  // One frame, 32 bit clocks per channel, left slot first.
  task automatic sendFrame(input logic fmt, input logic pad,
                           input logic [W-1:0] lw, input logic [W-1:0] rw);
    for (int ch = 0; ch < 2; ch++) begin
      logic [W-1:0] word;
      logic wc;
      word = (ch == 0) ? lw : rw;
      wc   = fmt ? (ch == 0) : (ch != 0);
      for (int s = 0; s < SLOT; s++) begin
        logic d;
        if (fmt) d = (s < W) ? word[W-1-s] : pad;
        else     d = (s >= 1 && s <= W) ? word[W-s] : pad;
        bitTick(wc, d);
      end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic frameCheck(input string req, input logic fmt, input logic pad,
                            input logic [W-1:0] lw, input logic [W-1:0] rw);
    int base;
    base = validCnt;
    sendFrame(fmt, pad, lw, rw);
    check(req, "strobe count", 32'(validCnt - base), 32'd1);
    check(req, "left sample", 32'(capL), 32'(lw));
    check(req, "right sample", 32'(capR), 32'(rw));
  endtask

  // {fmt, pad, left, right}
  localparam logic [49:0] VEC [6] = '{
    {1'b0, 1'b0, 24'h123456, 24'hABCDEF},
    {1'b0, 1'b1, 24'h800000, 24'h7FFFFF},
    {1'b0, 1'b0, 24'h000001, 24'hFFFFFF},
    {1'b1, 1'b0, 24'hC0FFEE, 24'h0F1E2D},
    {1'b1, 1'b1, 24'h000001, 24'h800000},
    {1'b1, 1'b0, 24'h555555, 24'hAAAAAA}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1", "leftSample", 32'(leftSample), 32'd0);
    check("R1", "rightSample", 32'(rightSample), 32'd0);
    check("R1", "sampleValid", 32'(sampleValid), 32'd0);
    check("R1", "mute flags", 32'({leftMuted, rightMuted}), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "after release", 32'({sampleValid, leftMuted, rightMuted}), 32'd0);

    // Vector table: R2 (I2S), R3 (left-justified), R4 (pad bits set)
    sendFrame(1'b0, 1'b0, 24'h5A5A5A, 24'h5A5A5A);
    for (int i = 0; i < 6; i++) begin
      logic f, p;
      f = VEC[i][49];
      p = VEC[i][48];
      if (f != fmtLeftJust) begin
        fmtLeftJust = f;
        sendFrame(f, 1'b0, 24'h5A5A5A, 24'h5A5A5A);
      end
      frameCheck(f ? (p ? "R3/R4" : "R3") : (p ? "R2/R4" : "R2"),
                 f, p, VEC[i][47:24], VEC[i][23:0]);
    end

    // Zero-run mute in I2S framing.
    fmtLeftJust = 1'b0;
    sendFrame(1'b0, 1'b0, 24'h5A5A5A, 24'h5A5A5A);
    for (int k = 0; k < RUN - 1; k++) sendFrame(1'b0, 1'b0, '0, 24'h111111);
    check("R6", "left below run", 32'(leftMuted), 32'd0);
    sendFrame(1'b0, 1'b0, '0, 24'h111111);
    check("R6", "left at run", 32'(capLM), 32'd1);
    check("R6", "right independent", 32'(capRM), 32'd0);
    check("R5", "strobe after R6 frame", 32'(capR), 32'h111111);

    for (int k = 0; k < RUN - 1; k++) sendFrame(1'b0, 1'b0, '0, '0);
    check("R6", "right below run", 32'(rightMuted), 32'd0);
    sendFrame(1'b0, 1'b0, '0, '0);
    check("R9", "right flag at strobe", 32'(capRM), 32'd1);
    check("R9", "right sample at strobe", 32'(capR), 32'd0);
    check("R6", "left stays muted", 32'(capLM), 32'd1);

    // R7: LSB-only word releases left
    sendFrame(1'b0, 1'b0, 24'h000001, '0);
    check("R7", "left released", 32'(capLM), 32'd0);
    check("R7", "right still muted", 32'(capRM), 32'd1);
    for (int k = 0; k < RUN - 1; k++) sendFrame(1'b0, 1'b0, '0, '0);
    check("R7", "left count restarted", 32'(leftMuted), 32'd0);

    // R8: disable clears flags and counts
    @(negedge clk);
    zeroMuteEn = 1'b0;
    repeat (2) @(negedge clk);
    check("R8", "flags cleared", 32'({leftMuted, rightMuted}), 32'd0);
    zeroMuteEn = 1'b1;
    sendFrame(1'b0, 1'b0, '0, '0);
    check("R8", "left count cleared", 32'(leftMuted), 32'd0);
    check("R8", "right count cleared", 32'(rightMuted), 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule